// File: doc/BRIEF.md
# Clearable Word Memory with Separate Data Paths

This block is a synchronous 1024-word by 4-bit memory. Write data and read data travel on separate ports. All control inputs are active low: a select, a write strobe, a read-output enable and a bulk-clear request. A selected clear request zeroes the entire array over two consecutive clock edges. The first edge wipes the lower half of the address space and the second edge wipes the upper half. A clear request while deselected does nothing, so one shared clear line can serve several copies of the block, and only the selected ones are wiped.

Read data is registered. It appears one cycle after the read command is sampled. The output bus is not tristated. A separate active-low drive flag travels beside the data instead. Whenever that flag is inactive, the data lines carry zero. An enclosing level can turn the pair into a real three-state driver.

The two-edge clear places a second cycle behind each clear command. In that cycle, writes and reads aimed at the upper half see the wipe instead of the stored word. Accesses to the lower half proceed as normal.

Top module: `zclr_sram`

## Requirements
- R1: With `cs_n`=0, `we_n`=0 and `clr_n`=1 at a clock edge, `din` is stored at word `addr`.
- R2: With `cs_n`=0, `oe_n`=0, `we_n`=1 and `clr_n`=1 at an edge, the next cycle shows the stored word at `addr` on `dout`, with `dout_en_n`=0.
- R3: If any of `cs_n`=1, `oe_n`=1, `we_n`=0 or `clr_n`=0 holds at an edge, the next cycle has `dout_en_n`=1 and `dout`=0.
- R4: `clr_n`=0 together with `cs_n`=1 leaves every stored word unchanged.
- R5: `clr_n`=0 together with `cs_n`=0 at an edge zeroes words 0..511 at that edge and words 512..1023 at the following edge. After the second edge, every address reads 0.
- R6: When a write command and a clear request coincide at one edge, the clear wins and the write is discarded.
- R7: In the edge after a clear request, a write to an address with `addr[9]`=1 is discarded, while a write with `addr[9]`=0 is stored.
- R8: In the edge after a clear request, a read of an address with `addr[9]`=1 returns 0.
- R9: While `rst_ni`=0, `dout_en_n`=1 and `dout`=0, and no clear is pending after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of control and output registers (the array is not reset) |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read-output enable |
| clr_n | input | 1 | Active-low bulk-clear request |
| addr | input | 10 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Registered read data, zero when not driving |
| dout_en_n | output | 1 | Active-low drive flag for `dout` |

## Verification
The hardest case to reach is the lone cycle after a clear request. In that cycle, only the upper half is being wiped, and a read or write there must be swallowed while the lower half stays live. The bench reaches it by pulsing the clear for exactly one cycle. It then places a write or a read in the very next cycle, once with an upper address and once with a lower one. It also reads a lower word in that same cycle to show the first edge already cleared it.

// File: rtl/zclr_pkg.sv
package zclr_pkg;
  localparam int unsigned ADDR_W_DEF = 10;
  localparam int unsigned DATA_W_DEF = 4;

  // write command: selected, strobe low, no clear request
  function automatic logic wr_cmd(input logic cs_n, input logic we_n, input logic clr_n);
    return !cs_n && !we_n && clr_n;
  endfunction

  // read command: selected, output enabled, no write, no clear
  function automatic logic rd_cmd(input logic cs_n, input logic we_n, input logic oe_n,
                                  input logic clr_n);
    return !cs_n && !oe_n && we_n && clr_n;
  endfunction

  // clear only starts when selected
  function automatic logic clr_cmd(input logic cs_n, input logic clr_n);
    return !cs_n && !clr_n;
  endfunction
endpackage

// File: rtl/zclr_ctrl.sv
module zclr_ctrl
  import zclr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       cs_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic       clr_n,
  input  logic       addr_hi,
  output logic [1:0] wipe,
  output logic [1:0] wr,
  output logic       rd_go,
  output logic       rd_zero
);
  logic clr_now;
  logic wr_now;
  logic upper_pending_q;

  assign clr_now = clr_cmd(cs_n, clr_n);
  assign wr_now  = wr_cmd(cs_n, we_n, clr_n);
  assign rd_go   = rd_cmd(cs_n, we_n, oe_n, clr_n);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) upper_pending_q <= 1'b0;
    else         upper_pending_q <= clr_now;
  end

  assign wipe[0] = clr_now;
  assign wipe[1] = upper_pending_q;
  assign wr[0]   = wr_now && !addr_hi && !wipe[0];
  assign wr[1]   = wr_now &&  addr_hi && !wipe[1];
  assign rd_zero = wipe[1] && addr_hi;

  // R4
  upper_wipe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wipe[1] |-> $past(!cs_n && !clr_n));
  // R5
  lower_then_upper_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wipe[0] |=> wipe[1]);
  // R5
  upper_wipe_once_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wipe[1] && !wipe[0]) |=> !wipe[1]);
endmodule

// File: rtl/zclr_array.sv
module zclr_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [1:0]        wipe,
  input  logic [1:0]        wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned HALF_W     = ADDR_W - 1;
  localparam int unsigned HALF_DEPTH = 1 << HALF_W;

  logic [DATA_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] cells [HALF_DEPTH];

    always_ff @(posedge clk) begin
      if (wipe[b]) begin
        for (int i = 0; i < HALF_DEPTH; i++) cells[i] <= '0;
      end else if (wr[b]) begin
        cells[addr[HALF_W-1:0]] <= din;
      end
    end

    assign bank_rd[b] = cells[addr[HALF_W-1:0]];

    // R7
    wipe_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      !(wipe[b] && wr[b]));
  end

  assign rdata = bank_rd[addr[ADDR_W-1]];
endmodule

// File: rtl/zclr_outgate.sv
module zclr_outgate #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rd_go,
  input  logic              rd_zero,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en_n
);
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dout      <= '0;
      dout_en_n <= 1'b1;
    end else begin
      dout      <= (rd_go && !rd_zero) ? rdata : '0;
      dout_en_n <= !rd_go;
    end
  end

  // R3
  off_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    dout_en_n |-> (dout == '0));
  // R8
  wiped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_zero |=> (dout == '0));
endmodule

// File: rtl/zclr_sram.sv
module zclr_sram
  import zclr_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en_n
);
  logic [1:0]        wipe;
  logic [1:0]        wr;
  logic              rd_go;
  logic              rd_zero;
  logic [DATA_W-1:0] rdata;

  zclr_ctrl u_ctrl (
    .clk(clk), .rst_ni(rst_ni), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .clr_n(clr_n), .addr_hi(addr[ADDR_W-1]), .wipe(wipe), .wr(wr),
    .rd_go(rd_go), .rd_zero(rd_zero)
  );

  zclr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_ni(rst_ni), .wipe(wipe), .wr(wr), .addr(addr),
    .din(din), .rdata(rdata)
  );

  zclr_outgate #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_ni(rst_ni), .rd_go(rd_go), .rd_zero(rd_zero),
    .rdata(rdata), .dout(dout), .dout_en_n(dout_en_n)
  );

  // R2
  drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !dout_en_n |-> $past(!cs_n && !oe_n && we_n && clr_n));
  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs_n || oe_n || !we_n || !clr_n) |=> dout_en_n);
endmodule

// File: tb/zclr_sram_tb.sv
module zclr_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zclr_sram u_dut (
    .clk(clk), .rst_ni(rst_ni), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .clr_n(clr_n), .addr(addr), .din(din), .dout(dout), .dout_en_n(dout_en_n)
  );

  // drive at negedge, let one edge commit, return at next negedge
  task automatic step(input logic c, input logic w, input logic o, input logic r,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs_n = c; we_n = w; oe_n = o; clr_n = r; addr = a; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [DW-1:0] exp_d, input logic exp_en_n);
    checks++;
    if (dout !== exp_d || dout_en_n !== exp_en_n) begin
      failures++;
      $display("FAIL %s: dout=%h en_n=%b expected dout=%h en_n=%b",
               req, dout, dout_en_n, exp_d, exp_en_n);
    end
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1'b0, 1'b0, 1'b1, 1'b1, a, d);
  endtask

  task automatic rd_expect(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1'b0, 1'b1, 1'b0, 1'b1, a, '0);
    check(req, d, 1'b0);
  endtask

  task automatic idle();
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic t_reset();
    check("R9 reset", '0, 1'b1);
    rst_ni = 1'b1;
    idle();
    check("R9 after release", '0, 1'b1);
  endtask

  task automatic t_write_read();
    wr_word(10'd0, 4'h5);
    wr_word(10'd511, 4'hA);
    wr_word(10'd512, 4'h3);
    wr_word(10'd1023, 4'hC);
    rd_expect("R1 R2 addr0", 10'd0, 4'h5);
    rd_expect("R1 R2 addr511", 10'd511, 4'hA);
    rd_expect("R1 R2 addr512", 10'd512, 4'h3);
    rd_expect("R1 R2 addr1023", 10'd1023, 4'hC);
    wr_word(10'd0, 4'hF);
    rd_expect("R1 overwrite", 10'd0, 4'hF);
  endtask

  task automatic t_gating();
    step(1'b1, 1'b1, 1'b0, 1'b1, 10'd0, '0);
    check("R3 deselected", '0, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 10'd0, '0);
    check("R3 oe high", '0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 10'd200, 4'h6);
    check("R3 write active", '0, 1'b1);
    rd_expect("R1 write under oe", 10'd200, 4'h6);
  endtask

  task automatic t_desel_clear();
    step(1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
    step(1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
    check("R3 clear request output off", '0, 1'b1);
    rd_expect("R4 addr0 kept", 10'd0, 4'hF);
    rd_expect("R4 addr512 kept", 10'd512, 4'h3);
    rd_expect("R4 addr1023 kept", 10'd1023, 4'hC);
  endtask

  task automatic t_clear_phases();
    wr_word(10'd5, 4'hA);
    wr_word(10'd700, 4'h9);
    // clear request with read conditions also present
    step(1'b0, 1'b1, 1'b0, 1'b0, 10'd5, '0);
    check("R3 clear low output off", '0, 1'b1);
    rd_expect("R5 lower wiped at first edge", 10'd5, 4'h0);
    rd_expect("R5 upper wiped", 10'd700, 4'h0);
    for (int a = 0; a < (1 << AW); a++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1, a[AW-1:0], '0);
      if (dout !== '0 || dout_en_n !== 1'b0) check("R5 sweep", '0, 1'b0);
    end
    checks++;
  endtask

  task automatic t_upper_read_in_second();
    wr_word(10'd900, 4'h7);
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0);
    rd_expect("R8 upper read during wipe", 10'd900, 4'h0);
  endtask

  task automatic t_priority();
    wr_word(10'd3, 4'h7);
    step(1'b0, 1'b0, 1'b1, 1'b0, 10'd3, 4'hE);
    idle();
    rd_expect("R6 clear beats write", 10'd3, 4'h0);
  endtask

  task automatic t_second_cycle_write();
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0);
    wr_word(10'd800, 4'hC);
    rd_expect("R7 upper write dropped", 10'd800, 4'h0);
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0);
    wr_word(10'd100, 4'hB);
    rd_expect("R7 lower write kept", 10'd100, 4'hB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_gating();
    t_desel_clear();
    t_clear_phases();
    t_upper_read_in_second();
    t_priority();
    t_second_cycle_write();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule